// File: doc/BRIEF.md
# Bus Sync Arm and Trigger Counter

This block produces the timing strobes that a bus-monitoring pod needs while it watches a target processor. Each clock it decodes a two-bit sync-control code together with the target's data-access strobe and read/write line to form a data-sync strobe. From that strobe it derives two selectable clocks. The sync clock follows either the data-sync strobe or the target's address-pulse timing. The bus-cycle clock follows either the data-sync strobe or a ROM-module select line.

The block also keeps a sticky latch that records a target reset. A host preloads a down-counter through a small register write port and chooses an arm source: either an external arm line or the reset latch. Once armed, the counter steps on every sync-clock pulse. When it reaches zero it emits a one-cycle trigger and stops until the host preloads it again. The host can raise an overdrive request for one probe channel. The block drops that request at the same edge that raises the trigger, so the channel is overdriven for as short a time as possible.

Top module: `bus_sync_trigger`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output, including `cnt_o`, is 0 after that edge, and all mode bits clear to 0.
- R2: `data_sync_o` is registered from the same-cycle inputs. It is 1 when `data_strobe_i` is 1 and `sync_ctl_i` is 2'b01, or when `data_strobe_i` is 1, `rw_i` is 1 and `sync_ctl_i` is 2'b10. It is 0 for codes 2'b00 and 2'b11.
- R3: The control register is at address 0. `sync_clk_o` is registered: it equals the R2 data-sync value when control bit 3 is 0, and `addr_strobe_i` when bit 3 is 1.
- R4: `bus_clk_o` is registered: it equals the R2 data-sync value when control bit 4 is 0, and `rom_sel_i` when bit 4 is 1.
- R5: `tgt_reset_i` passes through a two-flop synchronizer. If it is held high, `reset_lat_o` goes to 1 at the third rising edge after it rose, and then stays high.
- R6: `reset_lat_o` clears when `sync_ctl_i` is 2'b11, or when `clr_req_i` is 1 while control bit 0 (clear mode) is 1. With clear mode at 0, `clr_req_i` has no effect. A synchronized reset wins over a clear.
- R7: With control bit 1 (arm enable) and bit 2 (arm select) both 1, a synchronized `arm_i` pulse sets `armed_o`. Arming needs both bits. `armed_o` stays set after `arm_i` falls.
- R8: With arm enable at 1 and arm select at 0, `reset_lat_o` is the arm source.
- R9: A write to address 1 loads `cnt_o` with the low bits of `reg_wdata`, clears `armed_o` and re-enables arming. The write takes priority over counting and firing in the same cycle. Writes to addresses 2 and 3 have no effect.
- R10: At each edge where `armed_o` and `sync_clk_o` are both 1, the counter decrements. When it holds 1, or was preloaded with 0, that edge raises `trig_o` for exactly one cycle and clears `armed_o`. The counter then rests at 0 and cannot re-arm until the next preload.
- R11: Writing address 0 with bit 5 set raises `ovd_o`. `ovd_o` falls at the same edge at which `trig_o` rises. A fire and a set in the same cycle leave `ovd_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | ADDR_W | Host register address (0 control, 1 preload) |
| reg_wdata | input | DATA_W | Host write data |
| tgt_reset_i | input | 1 | Asynchronous target reset indication |
| arm_i | input | 1 | Asynchronous external arm |
| clr_req_i | input | 1 | Reset-latch clear request |
| sync_ctl_i | input | 2 | Sync-control code |
| data_strobe_i | input | 1 | Target data-access strobe |
| rw_i | input | 1 | Target read (1) / write (0) |
| addr_strobe_i | input | 1 | Target address-pulse timing |
| rom_sel_i | input | 1 | ROM-module select timing |
| data_sync_o | output | 1 | Decoded data-sync strobe |
| sync_clk_o | output | 1 | Selected sync clock |
| bus_clk_o | output | 1 | Selected bus-cycle clock |
| reset_lat_o | output | 1 | Target reset latch |
| armed_o | output | 1 | Counter armed |
| trig_o | output | 1 | One-cycle trigger at terminal count |
| ovd_o | output | 1 | Overdrive request |
| cnt_o | output | CNT_W | Current counter value |

## Verification
The bench builds the block with an 8-bit counter and keeps the 16-bit write data. Preload writes therefore carry high bits that must be discarded, and terminal counts are reached in a few dozen sync pulses. The synchronizer depth stays at its default of two, so the R5 latency the bench expects is exact. Directed phases cover each arm source, a zero preload, clear-mode gating and the overdrive release. A long mixed phase then sends random writes, strobes and codes against the reference model.

// File: rtl/bst_pkg.sv
// Package: shared control-register layout and sync-control codes.
// Assumes: register field positions are fixed by the host software map.
package bst_pkg;

    // Sync-control codes decoded by the timing block.
    typedef enum logic [1:0] {
        SC_OFF   = 2'b00,
        SC_ALL   = 2'b01,
        SC_READS = 2'b10,
        SC_CLEAR = 2'b11
    } sync_code_e;

    // Stored mode bits, ordered to match the write-data bit positions 4..0.
    typedef struct packed {
        logic bclk_rom;   // bit 4: bus-cycle clock from ROM select
        logic sclk_addr;  // bit 3: sync clock from address timing
        logic arm_ext;    // bit 2: external arm source
        logic arm_en;     // bit 1: arming allowed
        logic clr_mode;   // bit 0: clear request active
    } mode_t;

    localparam int MODE_W   = 5;
    localparam int OVD_BIT  = 5;
    localparam int ADR_MODE = 0;
    localparam int ADR_LOAD = 1;

endpackage

// File: rtl/bst_sync.sv
// Module: multi-stage synchronizer for asynchronous level inputs.
// Assumes: inputs are levels that stay stable for at least STAGES clocks.
module bst_sync #(
    parameter int STAGES = 2,
    parameter int W      = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    // First stage captures the raw asynchronous level.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            // Each later stage retimes the one before it.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= '0;
                else        stg[g] <= stg[g-1];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/bst_regs.sv
// Module: host register port; holds the mode bits and emits write strobes.
// Assumes: one write per strobe cycle; unmapped addresses are ignored.
module bst_regs
    import bst_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output mode_t             mode,
    output logic              load_stb,
    output logic [CNT_W-1:0]  load_val,
    output logic              ovd_set
);

    logic  mode_wr;
    mode_t mode_q;

    // Decode the address into per-register write strobes.
    always_comb begin
        mode_wr  = reg_wr && (reg_addr == ADDR_W'(ADR_MODE));
        load_stb = reg_wr && (reg_addr == ADDR_W'(ADR_LOAD));
        ovd_set  = mode_wr && reg_wdata[OVD_BIT];
        load_val = reg_wdata[CNT_W-1:0];
    end

    // Hold the mode bits written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= '0;
        else if (mode_wr) mode_q <= mode_t'(reg_wdata[MODE_W-1:0]);
    end

    assign mode = mode_q;

endmodule

// File: rtl/bst_timing.sv
// Module: data-sync decode, sync/bus-cycle clock selection and reset latch.
// Assumes: bus strobes are already in the clock domain; tgt_rst is synchronized.
module bst_timing
    import bst_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  mode_t      mode,
    input  logic [1:0] sync_ctl,
    input  logic       data_strobe,
    input  logic       rw,
    input  logic       addr_strobe,
    input  logic       rom_sel,
    input  logic       clr_req,
    input  logic       tgt_rst,
    output logic       data_sync,
    output logic       sync_clk,
    output logic       bus_clk,
    output logic       reset_lat
);

    sync_code_e code;
    logic       ds_n, sc_n, bc_n, clr_n;
    logic       ds_q, sc_q, bc_q, lat_q;

    // Decode the code and select the next strobe values.
    always_comb begin
        code = sync_code_e'(sync_ctl);
        unique case (code)
            SC_ALL:   ds_n = data_strobe;
            SC_READS: ds_n = data_strobe & rw;
            default:  ds_n = 1'b0;
        endcase
        sc_n  = mode.sclk_addr ? addr_strobe : ds_n;
        bc_n  = mode.bclk_rom  ? rom_sel     : ds_n;
        clr_n = (code == SC_CLEAR) || (mode.clr_mode && clr_req);
    end

    // Register the three timing outputs together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ds_q <= 1'b0;
            sc_q <= 1'b0;
            bc_q <= 1'b0;
        end else begin
            ds_q <= ds_n;
            sc_q <= sc_n;
            bc_q <= bc_n;
        end
    end

    // Reset latch: set has priority over either clear source.
    always_ff @(posedge clk) begin
        if (!rst_n)       lat_q <= 1'b0;
        else if (tgt_rst) lat_q <= 1'b1;
        else if (clr_n)   lat_q <= 1'b0;
    end

    assign data_sync = ds_q;
    assign sync_clk  = sc_q;
    assign bus_clk   = bc_q;
    assign reset_lat = lat_q;

endmodule

// File: rtl/bst_arm_cnt.sv
// Module: sticky arm state, preloaded down-counter, trigger and overdrive release.
// Assumes: sync_clk is a registered one-cycle-per-pulse level from bst_timing.
module bst_arm_cnt
    import bst_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  mode_t            mode,
    input  logic             arm_ext,
    input  logic             reset_lat,
    input  logic             sync_clk,
    input  logic             load_stb,
    input  logic [CNT_W-1:0] load_val,
    input  logic             ovd_set,
    output logic             armed,
    output logic             trig,
    output logic             ovd,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic             armed_q, done_q, trig_q, ovd_q;
    logic [CNT_W-1:0] cnt_q;
    logic             src, step, fire, arm_now;

    // Choose the arm source and form the step and fire conditions.
    always_comb begin
        src     = mode.arm_ext ? arm_ext : reset_lat;
        step    = armed_q && sync_clk && !load_stb;
        fire    = step && (cnt_q <= ONE);
        arm_now = !armed_q && !done_q && mode.arm_en && src && !load_stb;
    end

    // Counter: preload wins, otherwise decrement toward zero on each step.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt_q <= '0;
        else if (load_stb)             cnt_q <= load_val;
        else if (step && cnt_q != '0)  cnt_q <= cnt_q - ONE;
    end

    // Sticky arm and done flags; done blocks re-arming until the next preload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            done_q  <= 1'b0;
        end else if (load_stb) begin
            armed_q <= 1'b0;
            done_q  <= 1'b0;
        end else if (fire) begin
            armed_q <= 1'b0;
            done_q  <= 1'b1;
        end else if (arm_now) begin
            armed_q <= 1'b1;
        end
    end

    // One-cycle trigger pulse at terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_q <= 1'b0;
        else        trig_q <= fire;
    end

    // Overdrive request: host sets it, the trigger edge drops it.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovd_q <= 1'b0;
        else if (fire)    ovd_q <= 1'b0;
        else if (ovd_set) ovd_q <= 1'b1;
    end

    assign armed = armed_q;
    assign trig  = trig_q;
    assign ovd   = ovd_q;
    assign cnt   = cnt_q;

endmodule

// File: rtl/bus_sync_trigger.sv
// Module: top level; synchronizes asynchronous inputs and wires the register,
// timing and counter blocks together.
// Assumes: CNT_W <= DATA_W; bus strobes arrive in the clk domain.
module bus_sync_trigger
    import bst_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              tgt_reset_i,
    input  logic              arm_i,
    input  logic              clr_req_i,
    input  logic [1:0]        sync_ctl_i,
    input  logic              data_strobe_i,
    input  logic              rw_i,
    input  logic              addr_strobe_i,
    input  logic              rom_sel_i,
    output logic              data_sync_o,
    output logic              sync_clk_o,
    output logic              bus_clk_o,
    output logic              reset_lat_o,
    output logic              armed_o,
    output logic              trig_o,
    output logic              ovd_o,
    output logic [CNT_W-1:0]  cnt_o
);

    localparam int ASYNC_W = 2;

    mode_t              mode;
    logic               load_stb, ovd_set;
    logic [CNT_W-1:0]   load_val;
    logic [ASYNC_W-1:0] async_raw, async_s;
    logic               sclk;

    assign async_raw = {arm_i, tgt_reset_i};

    bst_sync #(.STAGES(SYNC_STAGES), .W(ASYNC_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (async_raw),
        .q     (async_s)
    );

    bst_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .mode      (mode),
        .load_stb  (load_stb),
        .load_val  (load_val),
        .ovd_set   (ovd_set)
    );

    bst_timing u_timing (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode),
        .sync_ctl    (sync_ctl_i),
        .data_strobe (data_strobe_i),
        .rw          (rw_i),
        .addr_strobe (addr_strobe_i),
        .rom_sel     (rom_sel_i),
        .clr_req     (clr_req_i),
        .tgt_rst     (async_s[0]),
        .data_sync   (data_sync_o),
        .sync_clk    (sclk),
        .bus_clk     (bus_clk_o),
        .reset_lat   (reset_lat_o)
    );

    bst_arm_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .arm_ext   (async_s[1]),
        .reset_lat (reset_lat_o),
        .sync_clk  (sclk),
        .load_stb  (load_stb),
        .load_val  (load_val),
        .ovd_set   (ovd_set),
        .armed     (armed_o),
        .trig      (trig_o),
        .ovd       (ovd_o),
        .cnt       (cnt_o)
    );

    assign sync_clk_o = sclk;

endmodule

// File: rtl/bst_checker.sv
// Module: property checker bound to bus_sync_trigger; observes ports only.
// Assumes: synchronous active-low reset on rst_n.
module bst_checker #(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [1:0]        sync_ctl_i,
    input logic              data_sync_o,
    input logic              armed_o,
    input logic              trig_o,
    input logic              ovd_o,
    input logic [CNT_W-1:0]  cnt_o
);

    logic load_w;
    assign load_w = reg_wr && (reg_addr == ADDR_W'(1));

    // R10: the trigger never lasts two cycles.
    a_r10_trig_single: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |=> !trig_o);

    // R10: the trigger edge also disarms the counter.
    a_r10_trig_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> !armed_o);

    // R10: an unarmed counter holds its value unless preloaded.
    a_r10_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_o && !load_w) |=> $stable(cnt_o));

    // R11: overdrive is released by the time the trigger is visible.
    a_r11_ovd_release: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> !ovd_o);

    // R9: a preload write lands in the counter and leaves it unarmed.
    a_r9_preload: assert property (@(posedge clk) disable iff (!rst_n)
        load_w |=> (cnt_o == $past(reg_wdata[CNT_W-1:0])) && !armed_o);

    // R2: codes off and clear never produce a data-sync strobe.
    a_r2_code_off: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_ctl_i == 2'b00 || sync_ctl_i == 2'b11) |=> !data_sync_o);

endmodule

bind bus_sync_trigger bst_checker #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .sync_ctl_i (sync_ctl_i),
    .data_sync_o(data_sync_o),
    .armed_o    (armed_o),
    .trig_o     (trig_o),
    .ovd_o      (ovd_o),
    .cnt_o      (cnt_o)
);

// File: tb/bus_sync_trigger_bench.sv
module bus_sync_trigger_bench;

    localparam int CW = 8;
    localparam int DW = 16;
    localparam int AW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic          tgt_reset_i = 1'b0, arm_i = 1'b0, clr_req_i = 1'b0;
    logic [1:0]    sync_ctl_i = 2'b00;
    logic          data_strobe_i = 1'b0, rw_i = 1'b0, addr_strobe_i = 1'b0, rom_sel_i = 1'b0;
    logic          data_sync_o, sync_clk_o, bus_clk_o, reset_lat_o, armed_o, trig_o, ovd_o;
    logic [CW-1:0] cnt_o;

    always #4 clk = ~clk;

    bus_sync_trigger #(.CNT_W(CW), .DATA_W(DW), .ADDR_W(AW)) u_bus_sync_trigger (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .tgt_reset_i(tgt_reset_i), .arm_i(arm_i),
        .clr_req_i(clr_req_i), .sync_ctl_i(sync_ctl_i), .data_strobe_i(data_strobe_i),
        .rw_i(rw_i), .addr_strobe_i(addr_strobe_i), .rom_sel_i(rom_sel_i),
        .data_sync_o(data_sync_o), .sync_clk_o(sync_clk_o), .bus_clk_o(bus_clk_o),
        .reset_lat_o(reset_lat_o), .armed_o(armed_o), .trig_o(trig_o),
        .ovd_o(ovd_o), .cnt_o(cnt_o)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit model_on = 0;

    // Behavioural reference state
    int m_ds, m_sc, m_bc, m_lat, m_arm, m_done, m_trig, m_ovd, m_cnt;
    int m_mode;
    int q_rst[$], q_arm[$];

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Reference model, one step per rising edge
    always @(posedge clk) begin
        int ds, sc, bc, lat, src, load, mw, fire, stp, rs, as;
        cyc++;
        if (!rst_n) begin
            m_ds = 0; m_sc = 0; m_bc = 0; m_lat = 0; m_arm = 0; m_done = 0;
            m_trig = 0; m_ovd = 0; m_cnt = 0; m_mode = 0;
            q_rst = '{0, 0}; q_arm = '{0, 0};
        end else begin
            rs = q_rst[0]; as = q_arm[0];
            void'(q_rst.pop_front()); q_rst.push_back(int'(tgt_reset_i));
            void'(q_arm.pop_front()); q_arm.push_back(int'(arm_i));
            ds = 0;
            if (data_strobe_i && sync_ctl_i == 2'b01) ds = 1;
            if (data_strobe_i && rw_i && sync_ctl_i == 2'b10) ds = 1;
            sc = m_mode[3] ? int'(addr_strobe_i) : ds;
            bc = m_mode[4] ? int'(rom_sel_i) : ds;
            lat = m_lat;
            if (rs) lat = 1;
            else if (sync_ctl_i == 2'b11 || (m_mode[0] && clr_req_i)) lat = 0;
            src  = m_mode[2] ? as : m_lat;
            load = (reg_wr && reg_addr == 1);
            mw   = (reg_wr && reg_addr == 0);
            stp  = m_arm && m_sc && !load;
            fire = stp && m_cnt <= 1;
            m_trig = fire;
            if (fire) m_ovd = 0;
            else if (mw && reg_wdata[5]) m_ovd = 1;
            if (load) begin
                m_cnt = reg_wdata % (1 << CW); m_arm = 0; m_done = 0;
            end else begin
                if (stp && m_cnt > 0) m_cnt = m_cnt - 1;
                if (fire) begin m_arm = 0; m_done = 1; end
                else if (!m_arm && !m_done && m_mode[1] && src) m_arm = 1;
            end
            if (mw) m_mode = reg_wdata & 16'h1F;
            m_ds = ds; m_sc = sc; m_bc = bc; m_lat = lat;
        end
    end

    // Compare every output against the model away from the edge
    always @(negedge clk) begin
        if (model_on) begin
            chk("R2",  int'(data_sync_o), m_ds);
            chk("R3",  int'(sync_clk_o),  m_sc);
            chk("R4",  int'(bus_clk_o),   m_bc);
            chk("R6",  int'(reset_lat_o), m_lat);
            chk("R7",  int'(armed_o),     m_arm);
            chk("R10", int'(trig_o),      m_trig);
            chk("R11", int'(ovd_o),       m_ovd);
            chk("R9",  int'(cnt_o),       m_cnt);
        end
    end

    task automatic step(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(int a, int d);
        reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = DW'(d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rand_bus(int n);
        for (int i = 0; i < n; i++) begin
            sync_ctl_i    = 2'($urandom_range(0, 2));
            data_strobe_i = 1'($urandom);
            rw_i          = 1'($urandom);
            addr_strobe_i = 1'($urandom);
            rom_sel_i     = 1'($urandom);
            @(negedge clk);
        end
    endtask

    task automatic wait_trig(string req, int limit);
        int seen = 0;
        for (int i = 0; i < limit && !seen; i++) begin
            if (trig_o) seen = 1; else @(negedge clk);
        end
        chk(req, seen, 1);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        step(3);
        // R1: reset state at the ports
        chk("R1", int'({data_sync_o, sync_clk_o, bus_clk_o, reset_lat_o,
                        armed_o, trig_o, ovd_o}), 0);
        chk("R1", int'(cnt_o), 0);
        rst_n = 1'b1;
        model_on = 1;

        // R2 R3 R4: default selections, then the alternate timings
        rand_bus(60);
        wr(0, 32'h18);
        rand_bus(60);
        sync_ctl_i = 2'b10; data_strobe_i = 1; rw_i = 0;
        step(1);
        wr(0, 32'h00);
        step(1);
        chk("R2", int'(data_sync_o), 0);
        sync_ctl_i = 2'b00; data_strobe_i = 0;

        // R5: synchronizer latency of the reset latch
        tgt_reset_i = 1; step(2);
        chk("R5", int'(reset_lat_o), 0);
        step(1);
        chk("R5", int'(reset_lat_o), 1);
        tgt_reset_i = 0; step(3);

        // R6: clear request ignored without clear mode, honoured with it
        clr_req_i = 1; step(2);
        chk("R6", int'(reset_lat_o), 1);
        wr(0, 32'h01); step(1);
        chk("R6", int'(reset_lat_o), 0);
        clr_req_i = 0;
        tgt_reset_i = 1; step(4); tgt_reset_i = 0; step(3);
        sync_ctl_i = 2'b11; step(1); sync_ctl_i = 2'b00;
        chk("R6", int'(reset_lat_o), 0);

        // R7: external arm needs both bits; arm is sticky
        wr(1, 32'h0105);                // high byte dropped by the 8-bit counter
        chk("R9", int'(cnt_o), 5);
        wr(0, 32'h04);                  // select without enable
        arm_i = 1; step(4); arm_i = 0; step(3);
        chk("R7", int'(armed_o), 0);
        wr(0, 32'h26);                  // enable, external, overdrive set
        chk("R11", int'(ovd_o), 1);
        arm_i = 1; step(3); arm_i = 0; step(4);
        chk("R7", int'(armed_o), 1);
        sync_ctl_i = 2'b01; data_strobe_i = 1;
        wait_trig("R10", 40);
        chk("R11", int'(ovd_o), 0);
        chk("R10", int'(cnt_o), 0);
        step(1);
        chk("R10", int'(trig_o), 0);
        arm_i = 1; step(4); arm_i = 0; step(2);
        chk("R10", int'(armed_o), 0);   // no re-arm without preload
        data_strobe_i = 0;

        // R9: unmapped address leaves the counter alone
        wr(2, 32'h33); step(1);
        chk("R9", int'(cnt_o), 0);

        // R8: arm from the reset latch, with a zero preload firing on first tick
        wr(1, 0);
        wr(0, 32'h02);
        tgt_reset_i = 1; step(4); tgt_reset_i = 0;
        chk("R8", int'(armed_o), 1);
        data_strobe_i = 1;
        wait_trig("R10", 10);
        chk("R10", int'(cnt_o), 0);
        wr(1, 3);
        wait_trig("R8", 20);
        data_strobe_i = 0; sync_ctl_i = 2'b11; step(1); sync_ctl_i = 2'b00;

        // Mixed random phase
        for (int k = 0; k < 3000; k++) begin
            int r = $urandom_range(0, 99);
            if (r < 3) begin
                reg_wr = 1; reg_addr = AW'($urandom_range(0, 3));
                reg_wdata = DW'($urandom & 32'hFFFF);
                if (reg_addr == 1) reg_wdata[7:0] = 8'($urandom_range(0, 12));
            end else reg_wr = 0;
            tgt_reset_i   = ($urandom_range(0, 99) < 4);
            arm_i         = ($urandom_range(0, 99) < 10);
            clr_req_i     = 1'($urandom);
            sync_ctl_i    = 2'($urandom);
            data_strobe_i = 1'($urandom);
            rw_i          = 1'($urandom);
            addr_strobe_i = 1'($urandom);
            rom_sel_i     = 1'($urandom);
            @(negedge clk);
        end
        reg_wr = 0;
        step(2);
        finish_run();
    end

endmodule